// File: doc/BRIEF.md
# Interprocessor Doorbell and Interrupt Controller

This block sits between a host processor and an offload microcontroller and carries the signalling that their shared command rings need. The host rings outgoing channels in two steps: it first marks the channel busy with a one-hot write, then names the channel. The channel name reaches the remote side as a single-cycle pulse. The remote side raises incoming channels with a strobe. Each raised channel becomes a pending bit. A mask turns the pending bits into a level interrupt toward the host, and the host clears them with a write-one-to-clear acknowledge.

Two register banks hold ring-control words. The host writes the scratch words and the remote side reads them. The remote side writes the shadow words, and the host reads them but cannot change them. A second mask gates the busy bits onto an interrupt toward the remote side. Host accesses use a simple 32-bit register bus with byte offsets. Read data is combinational and follows `busAddr` in the same cycle. Every register update takes effect at the next clock edge.

Top module: `ipc_doorbell`

## Requirements
- R1: While `rstN` is low and after it is released, the pending bits, busy bits, start word, mask 1, all scratch and shadow words and the doorbell pulse are zero. Mask 0 comes up as 0x82 (channels 1 and 7 enabled), so `hostIrq` is low.
- R2: A host write to offset 0x004 sets every busy bit n whose data bit n (bits 7:0) is one and leaves the other busy bits unchanged. `remBusyClr` clears the busy bits it names. When a host set and a remote clear hit one bit in the same cycle, the bit ends up set. Offset 0x004 reads back the busy bits in bits 7:0, and `remBusy` shows them.
- R3: A host write to offset 0x00C raises `bellValid` for exactly the next cycle, with `bellChan` equal to data bits 7:0. Writes in consecutive cycles each give their own pulse.
- R4: `remSetValid` with `remSetChan` below 8 sets pending bit `remSetChan`. A channel number of 8 or more changes nothing. Offset 0x010 reads the pending bits in bits 7:0, and the bits above read as zero.
- R5: A host write to offset 0x014 clears every pending bit whose data bit is one. A remote set of the same bit in the same cycle wins, and the bit stays set.
- R6: Mask 0 lives at offset 0x018 (bits 7:0 are kept; the bits above read as zero). `hostIrq` is high exactly when some pending bit has its mask 0 bit set.
- R7: Mask 1 lives at offset 0x01C (bits 7:0 are kept). `remIrq` is high exactly when some busy bit has its mask 1 bit set.
- R8: Eight scratch words are host read/write. Offsets 0x020, 0x024, 0x028 and 0x02C are indices 0 to 3; offsets 0x050 to 0x05C are indices 4 to 7. Word `remScratchIdx` appears on `remScratchData`.
- R9: Eight shadow words are read-only to the host. Offsets 0x030 to 0x03C are indices 0 to 3; offsets 0x060 to 0x06C are indices 4 to 7. A pulse of `remShadowWe` loads `remShadowData` into word `remShadowIdx`. Host writes to these offsets are ignored.
- R10: The start word at offset 0x008 is full-width host read/write and is driven on `remStart`.
- R11: Every other offset reads as zero. This includes unaligned offsets, 0x000, the write-only offsets 0x00C and 0x014, and the gaps 0x040 to 0x04C and 0x070 upward. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Host access valid this cycle |
| busWrite | input | 1 | Host access is a write |
| busAddr | input | 8 | Host byte offset |
| busWdata | input | DATA_W | Host write data |
| busRdata | output | DATA_W | Host read data for busAddr (combinational) |
| hostIrq | output | 1 | Level interrupt toward the host |
| bellValid | output | 1 | One-cycle doorbell pulse toward the remote side |
| bellChan | output | 8 | Channel number carried by the doorbell pulse |
| remBusy | output | NUM_CH | Busy bits seen by the remote side |
| remIrq | output | 1 | Level interrupt toward the remote side |
| remBusyClr | input | NUM_CH | Remote clear mask for busy bits |
| remSetValid | input | 1 | Remote strobe raising an incoming channel |
| remSetChan | input | 8 | Incoming channel number |
| remShadowWe | input | 1 | Remote shadow word write strobe |
| remShadowIdx | input | 3 | Shadow word index |
| remShadowData | input | DATA_W | Shadow word data |
| remScratchIdx | input | 3 | Scratch word index for the remote read port |
| remScratchData | output | DATA_W | Selected scratch word |
| remStart | output | DATA_W | Start word |

## Verification
Two pairs of functions can land on the same bit in the same cycle. A host acknowledge can meet a remote channel raise, and a host busy set can meet a remote busy clear. The bench provokes both collisions with directed cycles that target one bit from each side. It also produces them often in a long random stream, where acknowledges, raises and clears are all drawn for every cycle. In each collision the outcome is judged by reading the status and busy registers back after the edge and comparing them with a model in which the setting side always wins.

// File: rtl/ipc_doorbell_pkg.sv
package ipc_doorbell_pkg;

  localparam int OFFS_W   = 8;
  localparam int NUM_WORD = 8;
  localparam int WIDX_W   = $clog2(NUM_WORD);

  localparam logic [OFFS_W-1:0] OFF_BUSY  = 8'h04;
  localparam logic [OFFS_W-1:0] OFF_START = 8'h08;
  localparam logic [OFFS_W-1:0] OFF_BELL  = 8'h0C;
  localparam logic [OFFS_W-1:0] OFF_STAT  = 8'h10;
  localparam logic [OFFS_W-1:0] OFF_ACK   = 8'h14;
  localparam logic [OFFS_W-1:0] OFF_MASK0 = 8'h18;
  localparam logic [OFFS_W-1:0] OFF_MASK1 = 8'h1C;

  localparam logic [3:0] SCR_NIB_LO = 4'h2;
  localparam logic [3:0] SHD_NIB_LO = 4'h3;
  localparam logic [3:0] SCR_NIB_HI = 4'h5;
  localparam logic [3:0] SHD_NIB_HI = 4'h6;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_BUSY,
    RD_START,
    RD_STAT,
    RD_MASK0,
    RD_MASK1,
    RD_SCR,
    RD_SHD
  } rdSel_e;

  typedef struct packed {
    logic              wrBusy;
    logic              wrStart;
    logic              wrBell;
    logic              wrAck;
    logic              wrMask0;
    logic              wrMask1;
    logic              wrScr;
    logic [WIDX_W-1:0] idx;
    rdSel_e            rdSel;
  } dpStrobe_t;

endpackage

// File: rtl/ipc_doorbell_ctrl.sv
module ipc_doorbell_ctrl
  import ipc_doorbell_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [OFFS_W-1:0] busAddr,
  output dpStrobe_t         stb
);

  logic wrEn;
  logic aligned;
  logic [3:0] nib;

  assign wrEn    = busSel & busWrite;
  assign aligned = (busAddr[1:0] == 2'b00);
  assign nib     = busAddr[7:4];

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    stb.idx   = {busAddr[6], busAddr[3:2]};
    case (busAddr)
      OFF_BUSY:  begin stb.rdSel = RD_BUSY;  stb.wrBusy  = wrEn; end
      OFF_START: begin stb.rdSel = RD_START; stb.wrStart = wrEn; end
      OFF_BELL:  begin stb.wrBell = wrEn; end
      OFF_STAT:  begin stb.rdSel = RD_STAT; end
      OFF_ACK:   begin stb.wrAck = wrEn; end
      OFF_MASK0: begin stb.rdSel = RD_MASK0; stb.wrMask0 = wrEn; end
      OFF_MASK1: begin stb.rdSel = RD_MASK1; stb.wrMask1 = wrEn; end
      default: begin
        if (aligned && (nib == SCR_NIB_LO || nib == SCR_NIB_HI)) begin
          stb.rdSel = RD_SCR;
          stb.wrScr = wrEn;
        end else if (aligned && (nib == SHD_NIB_LO || nib == SHD_NIB_HI)) begin
          stb.rdSel = RD_SHD;
        end
      end
    endcase
  end

endmodule

// File: rtl/ipc_doorbell_dp.sv
module ipc_doorbell_dp
  import ipc_doorbell_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                NUM_CH    = 8,
  parameter logic [NUM_CH-1:0] MASK0_RST = 'h82
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              hostIrq,
  output logic              remIrq,
  output logic              bellValid,
  output logic [7:0]        bellChan,
  output logic [NUM_CH-1:0] remBusy,
  output logic [NUM_CH-1:0] pendVec,
  input  logic [NUM_CH-1:0] remBusyClr,
  input  logic              remSetValid,
  input  logic [7:0]        remSetChan,
  input  logic              remShadowWe,
  input  logic [WIDX_W-1:0] remShadowIdx,
  input  logic [DATA_W-1:0] remShadowData,
  input  logic [WIDX_W-1:0] remScratchIdx,
  output logic [DATA_W-1:0] remScratchData,
  output logic [DATA_W-1:0] remStart
);

  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] pendQ, busyQ, mask0Q, mask1Q;
  logic [NUM_CH-1:0] wrBits, setHot, ackMask, busySet;
  logic [DATA_W-1:0] startQ;
  logic              bellValidQ;
  logic [7:0]        bellChanQ;
  logic [DATA_W-1:0] scrQ [NUM_WORD];
  logic [DATA_W-1:0] shdQ [NUM_WORD];

  assign wrBits = busWdata[NUM_CH-1:0];

  always_comb begin
    setHot = '0;
    if (remSetValid && (int'(remSetChan) < NUM_CH)) setHot[remSetChan[CHW-1:0]] = 1'b1;
  end

  assign ackMask = stb.wrAck  ? wrBits : '0;
  assign busySet = stb.wrBusy ? wrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      busyQ  <= '0;
      mask0Q <= MASK0_RST;
      mask1Q <= '0;
      startQ <= '0;
    end else begin
      pendQ <= (pendQ & ~ackMask) | setHot;
      busyQ <= (busyQ & ~remBusyClr) | busySet;
      if (stb.wrMask0) mask0Q <= wrBits;
      if (stb.wrMask1) mask1Q <= wrBits;
      if (stb.wrStart) startQ <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bellValidQ <= 1'b0;
      bellChanQ  <= '0;
    end else begin
      bellValidQ <= stb.wrBell;
      if (stb.wrBell) bellChanQ <= busWdata[7:0];
    end
  end

  for (genvar g = 0; g < NUM_WORD; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) begin
        scrQ[g] <= '0;
        shdQ[g] <= '0;
      end else begin
        if (stb.wrScr && stb.idx == WIDX_W'(g)) scrQ[g] <= busWdata;
        if (remShadowWe && remShadowIdx == WIDX_W'(g)) shdQ[g] <= remShadowData;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (stb.rdSel)
      RD_BUSY:  busRdata[NUM_CH-1:0] = busyQ;
      RD_START: busRdata = startQ;
      RD_STAT:  busRdata[NUM_CH-1:0] = pendQ;
      RD_MASK0: busRdata[NUM_CH-1:0] = mask0Q;
      RD_MASK1: busRdata[NUM_CH-1:0] = mask1Q;
      RD_SCR:   busRdata = scrQ[stb.idx];
      RD_SHD:   busRdata = shdQ[stb.idx];
      default:  busRdata = '0;
    endcase
  end

  assign hostIrq        = |(pendQ & mask0Q);
  assign remIrq         = |(busyQ & mask1Q);
  assign bellValid      = bellValidQ;
  assign bellChan       = bellChanQ;
  assign remBusy        = busyQ;
  assign pendVec        = pendQ;
  assign remStart       = startQ;
  assign remScratchData = scrQ[remScratchIdx];

endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
  import ipc_doorbell_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                NUM_CH    = 8,
  parameter logic [NUM_CH-1:0] MASK0_RST = 'h82
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [7:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              hostIrq,
  output logic              bellValid,
  output logic [7:0]        bellChan,
  output logic [NUM_CH-1:0] remBusy,
  output logic              remIrq,
  input  logic [NUM_CH-1:0] remBusyClr,
  input  logic              remSetValid,
  input  logic [7:0]        remSetChan,
  input  logic              remShadowWe,
  input  logic [2:0]        remShadowIdx,
  input  logic [DATA_W-1:0] remShadowData,
  input  logic [2:0]        remScratchIdx,
  output logic [DATA_W-1:0] remScratchData,
  output logic [DATA_W-1:0] remStart
);

  dpStrobe_t         stb;
  logic [NUM_CH-1:0] pendVec;

  ipc_doorbell_ctrl u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .stb     (stb)
  );

  ipc_doorbell_dp #(
    .DATA_W   (DATA_W),
    .NUM_CH   (NUM_CH),
    .MASK0_RST(MASK0_RST)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .busWdata      (busWdata),
    .busRdata      (busRdata),
    .hostIrq       (hostIrq),
    .remIrq        (remIrq),
    .bellValid     (bellValid),
    .bellChan      (bellChan),
    .remBusy       (remBusy),
    .pendVec       (pendVec),
    .remBusyClr    (remBusyClr),
    .remSetValid   (remSetValid),
    .remSetChan    (remSetChan),
    .remShadowWe   (remShadowWe),
    .remShadowIdx  (remShadowIdx),
    .remShadowData (remShadowData),
    .remScratchIdx (remScratchIdx),
    .remScratchData(remScratchData),
    .remStart      (remStart)
  );

endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk
  import ipc_doorbell_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [7:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              hostIrq,
  input logic              remIrq,
  input logic              bellValid,
  input logic [NUM_CH-1:0] pendVec,
  input logic [NUM_CH-1:0] remBusy,
  input logic              remSetValid,
  input logic [7:0]        remSetChan,
  input logic              remShadowWe
);

  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // R2
  busy_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_BUSY)
    |=> ((remBusy & $past(busWdata[NUM_CH-1:0])) == $past(busWdata[NUM_CH-1:0])));

  // R3
  bell_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    bellValid |-> $past(busSel && busWrite && busAddr == OFF_BELL));

  // R4
  raise_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remSetValid && int'(remSetChan) < NUM_CH) |=> pendVec[$past(remSetChan[CHW-1:0])]);

  // R4
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFF_STAT) |-> (busRdata[DATA_W-1:NUM_CH] == '0));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr == OFF_ACK && !remSetValid)
    |=> ((pendVec & $past(busWdata[NUM_CH-1:0])) == '0));

  // R6
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec == '0) |-> !hostIrq);

  // R7
  remirq_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remBusy == '0) |-> !remIrq);

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == {SHD_NIB_LO, 4'h0} && $past(busAddr) == {SHD_NIB_LO, 4'h0} && !$past(remShadowWe))
    |-> $stable(busRdata));

endmodule

bind ipc_doorbell ipc_doorbell_chk #(
  .DATA_W(DATA_W),
  .NUM_CH(NUM_CH)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWrite   (busWrite),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .hostIrq    (hostIrq),
  .remIrq     (remIrq),
  .bellValid  (bellValid),
  .pendVec    (pendVec),
  .remBusy    (remBusy),
  .remSetValid(remSetValid),
  .remSetChan (remSetChan),
  .remShadowWe(remShadowWe)
);

// File: tb/ipc_doorbell_bench.sv
module ipc_doorbell_bench;

  localparam int DATA_W = 32;
  localparam int NUM_CH = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic              busSel, busWrite;
  logic [7:0]        busAddr;
  logic [DATA_W-1:0] busWdata, busRdata;
  logic              hostIrq, bellValid, remIrq;
  logic [7:0]        bellChan;
  logic [NUM_CH-1:0] remBusy, remBusyClr;
  logic              remSetValid;
  logic [7:0]        remSetChan;
  logic              remShadowWe;
  logic [2:0]        remShadowIdx, remScratchIdx;
  logic [DATA_W-1:0] remShadowData, remScratchData, remStart;

  ipc_doorbell u_ipc_doorbell (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hostIrq(hostIrq), .bellValid(bellValid),
    .bellChan(bellChan), .remBusy(remBusy), .remIrq(remIrq), .remBusyClr(remBusyClr),
    .remSetValid(remSetValid), .remSetChan(remSetChan), .remShadowWe(remShadowWe),
    .remShadowIdx(remShadowIdx), .remShadowData(remShadowData),
    .remScratchIdx(remScratchIdx), .remScratchData(remScratchData), .remStart(remStart)
  );

  // stimulus for the next cycle
  logic        sSel, sWr, sSetV, sShWe;
  logic [7:0]  sAddr, sSetCh, sClr;
  logic [31:0] sData, sShData;
  logic [2:0]  sShIdx, sScrIdx;

  // reference model
  logic [7:0]  mPend, mBusy, mMask0, mMask1, mBellCh;
  logic        mBellV;
  logic [31:0] mStart;
  logic [31:0] mScr [8];
  logic [31:0] mShd [8];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isScr(input logic [7:0] a);
    return (a[1:0] == 0) && (a[7:4] == 4'h2 || a[7:4] == 4'h5);
  endfunction

  function automatic bit isShd(input logic [7:0] a);
    return (a[1:0] == 0) && (a[7:4] == 4'h3 || a[7:4] == 4'h6);
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    if (a == 8'h04) return {24'b0, mBusy};
    if (a == 8'h08) return mStart;
    if (a == 8'h10) return {24'b0, mPend};
    if (a == 8'h18) return {24'b0, mMask0};
    if (a == 8'h1C) return {24'b0, mMask1};
    if (isScr(a)) return mScr[{a[6], a[3:2]}];
    if (isShd(a)) return mShd[{a[6], a[3:2]}];
    return 32'h0;
  endfunction

  function automatic string reqOf(input logic [7:0] a);
    if (a == 8'h04) return "R2 busy read";
    if (a == 8'h08) return "R10 start read";
    if (a == 8'h10) return "R4 status read";
    if (a == 8'h18) return "R6 mask0 read";
    if (a == 8'h1C) return "R7 mask1 read";
    if (isScr(a)) return "R8 scratch read";
    if (isShd(a)) return "R9 shadow read";
    return "R11 unmapped read";
  endfunction

  task automatic idleStim();
    sSel = 0; sWr = 0; sAddr = 8'h00; sData = 0;
    sSetV = 0; sSetCh = 0; sClr = 0;
    sShWe = 0; sShIdx = 0; sShData = 0; sScrIdx = 0;
  endtask

  task automatic modelReset();
    mPend = 0; mBusy = 0; mMask0 = 8'h82; mMask1 = 0; mStart = 0;
    mBellV = 0; mBellCh = 0;
    for (int i = 0; i < 8; i++) begin mScr[i] = 0; mShd[i] = 0; end
  endtask

  task automatic modelEdge();
    logic       w;
    logic [7:0] setHot, ack, bset;
    w = sSel && sWr;
    setHot = 0;
    if (sSetV && sSetCh < 8) setHot[sSetCh[2:0]] = 1'b1;
    ack  = (w && sAddr == 8'h14) ? sData[7:0] : 8'h0;
    bset = (w && sAddr == 8'h04) ? sData[7:0] : 8'h0;
    mPend  = (mPend & ~ack) | setHot;
    mBusy  = (mBusy & ~sClr) | bset;
    mBellV = w && sAddr == 8'h0C;
    if (mBellV) mBellCh = sData[7:0];
    if (w && sAddr == 8'h08) mStart = sData;
    if (w && sAddr == 8'h18) mMask0 = sData[7:0];
    if (w && sAddr == 8'h1C) mMask1 = sData[7:0];
    if (w && isScr(sAddr)) mScr[{sAddr[6], sAddr[3:2]}] = sData;
    if (sShWe) mShd[sShIdx] = sShData;
  endtask

  task automatic runCycle();
    @(negedge clk);
    busSel = sSel; busWrite = sWr; busAddr = sAddr; busWdata = sData;
    remSetValid = sSetV; remSetChan = sSetCh; remBusyClr = sClr;
    remShadowWe = sShWe; remShadowIdx = sShIdx; remShadowData = sShData;
    remScratchIdx = sScrIdx;
    #1;
    if (!sWr) chk(reqOf(sAddr), busRdata, modelRead(sAddr));
    @(posedge clk);
    modelEdge();
    #1;
    chk("R6 hostIrq", {31'b0, hostIrq}, {31'b0, |(mPend & mMask0)});
    chk("R7 remIrq", {31'b0, remIrq}, {31'b0, |(mBusy & mMask1)});
    chk("R2 remBusy", {24'b0, remBusy}, {24'b0, mBusy});
    chk("R3 bellValid", {31'b0, bellValid}, {31'b0, mBellV});
    if (mBellV) chk("R3 bellChan", {24'b0, bellChan}, {24'b0, mBellCh});
    chk("R10 remStart", remStart, mStart);
    chk("R8 remScratchData", remScratchData, mScr[sScrIdx]);
  endtask

  task automatic hostWr(input logic [7:0] a, input logic [31:0] d);
    idleStim(); sSel = 1; sWr = 1; sAddr = a; sData = d; runCycle();
  endtask

  task automatic hostRd(input logic [7:0] a);
    idleStim(); sSel = 1; sAddr = a; runCycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seedV = 32'h1D0B_E11;
    void'($urandom(seedV));
    idleStim();
    busSel = 0; busWrite = 0; busAddr = 0; busWdata = 0;
    remSetValid = 0; remSetChan = 0; remBusyClr = 0;
    remShadowWe = 0; remShadowIdx = 0; remShadowData = 0; remScratchIdx = 0;
    rstN = 0;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 hostIrq in reset", {31'b0, hostIrq}, 32'h0);
    chk("R1 bellValid in reset", {31'b0, bellValid}, 32'h0);
    @(negedge clk);
    rstN = 1;

    // R1 reset values
    hostRd(8'h18); chk("R1 mask0 reset", busRdata, 32'h82);
    hostRd(8'h10); chk("R1 status reset", busRdata, 32'h0);
    hostRd(8'h04); hostRd(8'h08); hostRd(8'h1C); hostRd(8'h20); hostRd(8'h6C);

    // R4 raise and ignored channel numbers
    idleStim(); sSetV = 1; sSetCh = 8'd1; runCycle();
    hostRd(8'h10); chk("R4 status after raise", busRdata, 32'h2);
    chk("R6 irq from ch1", {31'b0, hostIrq}, 32'h1);
    idleStim(); sSetV = 1; sSetCh = 8'd9; runCycle();
    hostRd(8'h10); chk("R4 out-of-range ignored", busRdata, 32'h2);

    // R5 acknowledge and collision
    hostWr(8'h14, 32'h2);
    hostRd(8'h10); chk("R5 ack clears", busRdata, 32'h0);
    idleStim(); sSel = 1; sWr = 1; sAddr = 8'h14; sData = 32'h80; sSetV = 1; sSetCh = 8'd7; runCycle();
    hostRd(8'h10); chk("R5 set beats ack", busRdata, 32'h80);

    // R6 masking
    hostWr(8'h18, 32'hFFFF_FF00);
    chk("R6 masked off", {31'b0, hostIrq}, 32'h0);
    hostRd(8'h18); chk("R6 mask upper bits dropped", busRdata, 32'h0);
    hostWr(8'h18, 32'h80);

    // R2 and R7 busy
    hostWr(8'h04, 32'h1);
    chk("R2 busy set", {24'b0, remBusy}, 32'h1);
    hostWr(8'h1C, 32'h1);
    chk("R7 remIrq on", {31'b0, remIrq}, 32'h1);
    idleStim(); sClr = 8'h1; runCycle();
    chk("R2 remote clear", {24'b0, remBusy}, 32'h0);
    idleStim(); sSel = 1; sWr = 1; sAddr = 8'h04; sData = 32'h1; sClr = 8'h1; runCycle();
    chk("R2 set beats clear", {24'b0, remBusy}, 32'h1);

    // R3 doorbell pulse and back-to-back
    hostWr(8'h0C, 32'h5);
    chk("R3 pulse chan", {24'b0, bellChan}, 32'h5);
    hostWr(8'h0C, 32'h0);
    chk("R3 second pulse", {31'b0, bellValid}, 32'h1);
    hostRd(8'h0C); chk("R3 pulse ends", {31'b0, bellValid}, 32'h0);

    // R8 scratch, R9 shadow, R10 start, R11 unmapped
    hostWr(8'h2C, 32'hCAFE_0003);
    hostWr(8'h50, 32'hBEEF_0004);
    idleStim(); sScrIdx = 3'd3; runCycle();
    chk("R8 remote scratch idx3", remScratchData, 32'hCAFE_0003);
    hostRd(8'h50);
    idleStim(); sShWe = 1; sShIdx = 3'd5; sShData = 32'h1234_5678; runCycle();
    hostRd(8'h64); chk("R9 shadow idx5", busRdata, 32'h1234_5678);
    hostWr(8'h64, 32'hFFFF_FFFF);
    hostRd(8'h64); chk("R9 host write ignored", busRdata, 32'h1234_5678);
    hostWr(8'h08, 32'hA5A5_5A5A);
    hostWr(8'h40, 32'hFFFF_FFFF);
    hostRd(8'h40); chk("R11 gap reads zero", busRdata, 32'h0);
    hostRd(8'h21); chk("R11 unaligned zero", busRdata, 32'h0);
    hostRd(8'h14);
    for (int a = 0; a < 128; a += 4) hostRd(8'(a));

    // random mix
    for (int it = 0; it < 4000; it++) begin
      idleStim();
      sSel  = ($urandom % 4) != 0;
      sWr   = sSel && ($urandom % 2);
      sAddr = ($urandom % 8 == 0) ? 8'($urandom) : 8'(($urandom % 32) * 4);
      if ($urandom % 3 == 0) sAddr = (($urandom % 2) != 0) ? 8'h14 : 8'h04;
      sData = $urandom;
      if ($urandom % 2) sData = sData & 32'hFF;
      sSetV   = ($urandom % 2);
      sSetCh  = 8'($urandom % 10);
      sClr    = (($urandom % 3) == 0) ? 8'($urandom) : 8'h0;
      sShWe   = ($urandom % 4) == 0;
      sShIdx  = 3'($urandom);
      sShData = $urandom;
      sScrIdx = 3'($urandom);
      runCycle();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule